// File: doc/BRIEF.md
# Hold Interpolator and Single-Bit Noise-Shaping Modulator

This block sits at the end of a digital audio playback path. It takes signed 16-bit audio that an earlier interpolation stage delivers at four times the frame rate (normal mode) or eight times the frame rate (double mode). It repeats each sample (a zero-order hold) so that every channel is always clocked at 64 times the frame rate. A fourth-order single-bit noise-shaping loop per channel then turns the held value into a pulse-density bitstream for an analog reconstruction filter.

All logic runs on a master clock at 384 times the frame rate. A divide-by-six counter makes the 64×Fs enable tick. Samples arrive with a one-cycle strobe at any time. The most recent one is latched and taken over only at the start of a hold period, so each value drives the loop for exactly 16 ticks (normal) or 8 ticks (double). A mute input clears the loop and replaces the stream with an idle alternating pattern.

Top module: `zoh_sdm`

## Requirements
- R1: `bits_vld_o` is high for one clock in every six. Its first pulse follows the sixth rising edge after reset is released. `bits_o` changes only on the edge that raises `bits_vld_o`.
- R2: While `rst_ni` is low, `bits_o` is all zeros and `bits_vld_o` is low. All integrators, held samples, phase and divider state are zero.
- R3: A hold phase counter advances on every tick. A tick taken while the phase is 0 is a hold boundary. In normal mode (`dbl_i`=0) the phase runs 0..15, so each held value feeds the loop for 16 ticks. A sample strobed between boundaries is stored and takes effect only at the next boundary. If several are strobed, the last one wins.
- R4: In double mode (`dbl_i`=1) the phase runs 0..7, so each held value lasts 8 ticks. When the mode changes mid-period, a phase at or beyond the new last value wraps to 0 on the next tick.
- R5: A strobe that falls in the same clock as a hold-boundary tick is used directly in that tick's loop update.
- R6: Per channel, each tick forms x = sample·64 (sign-extended to 24 bits) and f = +2^21 if the previous output bit was 1, else −2^21. Integrator updates: n0 = I0 + (x − f), n1 = I1 + (I0>>>1), n2 = I2 + (I1>>>2), n3 = I3 + (I2>>>3). The output bit is 1 when n0 + (n1>>>1) + (n2>>>2) + (n3>>>3) ≥ 0.
- R7: Every integrator update saturates to the range −(2^23−1) .. +(2^23−1) before it is stored.
- R8: On a tick with `mute_i`=1, all integrators are cleared and the output bit is forced. The first muted tick gives 1, then the bit alternates 0, 1, 0, … for as long as mute stays high.
- R9: After mute is released, the loop restarts from zero integrator state. The alternation restarts with 1 at the next mute.
- R10: Channel c reads `smp_i[16c+15:16c]` and drives `bits_o[c]`. Channels share timing and mode but not loop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 384×Fs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_i | input | 1 | 1 = double mode (8-tick hold), 0 = normal mode (16-tick hold) |
| mute_i | input | 1 | Clears the loops and emits the idle alternating pattern |
| smp_vld_i | input | 1 | One-cycle strobe qualifying `smp_i` |
| smp_i | input | 32 | Signed 16-bit samples, channel 0 in the low half |
| bits_o | output | 2 | Pulse-density output bits, one per channel |
| bits_vld_o | output | 1 | High in the cycle a new output bit appears (64×Fs) |

## Verification
Two functions can fall in the same cycle: the arrival of a new sample strobe and the hold-boundary tick that takes over the stored sample. The bench follows its own model of the divider and phase, and drives the strobe exactly in the clock before a boundary edge. It then judges the following output bits against a model that uses the fresh sample rather than the stale one. Strobes placed mid-period, mode switches and mute entry and exit are mixed into random streams. Every output bit is compared against that model.

// File: rtl/zoh_sdm_pkg.sv
package zoh_sdm_pkg;

    typedef enum logic {
        RATE_NORMAL = 1'b0,
        RATE_DOUBLE = 1'b1
    } rate_mode_e;

    // master clocks per 64x output tick (384 / 64)
    localparam int unsigned MCLK_PER_TICK = 6;

endpackage

// File: rtl/zoh_rate_gen.sv
module zoh_rate_gen
    import zoh_sdm_pkg::*;
#(
    parameter int unsigned DIV         = MCLK_PER_TICK,
    parameter int unsigned HOLD_NORMAL = 16,
    parameter int unsigned HOLD_DOUBLE = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dbl_i,
    output logic tick_o,
    output logic load_o
);
    localparam int unsigned DV_W = $clog2(DIV);
    localparam int unsigned PH_W = $clog2(HOLD_NORMAL);

    typedef struct packed {
        logic [DV_W-1:0] div;
        logic [PH_W-1:0] ph;
    } rg_state_t;

    rg_state_t  st_d, st_q;
    rate_mode_e mode;
    logic [PH_W-1:0] last_ph;

    assign mode = rate_mode_e'(dbl_i);

    always_comb begin
        st_d    = st_q;
        last_ph = (mode == RATE_DOUBLE) ? PH_W'(HOLD_DOUBLE - 1) : PH_W'(HOLD_NORMAL - 1);
        tick_o  = (st_q.div == DV_W'(DIV - 1));
        load_o  = tick_o && (st_q.ph == '0);
        if (tick_o) begin
            st_d.div = '0;
            // >= lets a mode change mid-period wrap cleanly
            st_d.ph  = (st_q.ph >= last_ph) ? '0 : st_q.ph + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/zoh_sdm_chan.sv
module zoh_sdm_chan #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned ACC_W = 24,
    parameter int unsigned ORDER = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            mute_i,
    input  logic [IN_W-1:0] x_i,
    output logic            bit_o
);
    localparam int unsigned SHIFT = ACC_W - IN_W - 2;
    localparam int unsigned SUM_W = ACC_W + 2;
    localparam logic signed [ACC_W-1:0] FB_P    = ACC_W'(2 ** (ACC_W - 3));
    localparam logic signed [ACC_W-1:0] LIM_POS = ACC_W'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LIM_NEG = -LIM_POS;
    localparam logic signed [ACC_W:0]   RLIM_P  = (ACC_W + 1)'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [ACC_W:0]   RLIM_N  = -RLIM_P;

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] ig;
        logic                        obit;
        logic                        mph;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic signed [ACC_W-1:0] xs, fb;
    logic signed [ACC_W-1:0] inc [ORDER];
    logic signed [ACC_W-1:0] nxt [ORDER];
    logic signed [ACC_W:0]   raw [ORDER];
    logic signed [SUM_W-1:0] vsum;

    always_comb begin
        st_d   = st_q;
        xs     = $signed({{(ACC_W - IN_W){x_i[IN_W-1]}}, x_i}) <<< SHIFT;
        fb     = st_q.obit ? FB_P : -FB_P;
        inc[0] = xs - fb;
        for (int k = 1; k < ORDER; k++) begin
            inc[k] = $signed(st_q.ig[k-1]) >>> k;
        end
        vsum = '0;
        for (int k = 0; k < ORDER; k++) begin
            raw[k] = $signed({st_q.ig[k][ACC_W-1], st_q.ig[k]}) + $signed({inc[k][ACC_W-1], inc[k]});
            if (raw[k] > RLIM_P)      nxt[k] = LIM_POS;
            else if (raw[k] < RLIM_N) nxt[k] = LIM_NEG;
            else                      nxt[k] = raw[k][ACC_W-1:0];
            vsum = vsum + SUM_W'(nxt[k] >>> k);
        end
        if (tick_i) begin
            if (mute_i) begin
                st_d.ig   = '0;
                st_d.obit = ~st_q.mph;
                st_d.mph  = ~st_q.mph;
            end else begin
                for (int k = 0; k < ORDER; k++) st_d.ig[k] = nxt[k];
                st_d.obit = ~vsum[SUM_W-1];
                st_d.mph  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bit_o = st_q.obit;

endmodule

// File: rtl/zoh_sdm.sv
module zoh_sdm
    import zoh_sdm_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned IN_W  = 16,
    parameter int unsigned ACC_W = 24
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                dbl_i,
    input  logic                mute_i,
    input  logic                smp_vld_i,
    input  logic [NCH*IN_W-1:0] smp_i,
    output logic [NCH-1:0]      bits_o,
    output logic                bits_vld_o
);
    typedef struct packed {
        logic [NCH-1:0][IN_W-1:0] pend;
        logic [NCH-1:0][IN_W-1:0] act;
        logic                     vld;
    } top_state_t;

    top_state_t st_d, st_q;
    logic tick_w, load_w;
    logic [NCH-1:0][IN_W-1:0] fresh, feed;
    logic [NCH*IN_W-1:0] act_w;

    zoh_rate_gen #(
        .DIV(MCLK_PER_TICK), .HOLD_NORMAL(16), .HOLD_DOUBLE(8)
    ) u_rate (
        .clk_i(clk_i), .rst_ni(rst_ni), .dbl_i(dbl_i),
        .tick_o(tick_w), .load_o(load_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = tick_w;
        for (int c = 0; c < NCH; c++) begin
            fresh[c] = smp_vld_i ? smp_i[c*IN_W +: IN_W] : st_q.pend[c];
            feed[c]  = load_w ? fresh[c] : st_q.act[c];
            if (smp_vld_i) st_d.pend[c] = smp_i[c*IN_W +: IN_W];
            if (load_w)    st_d.act[c]  = fresh[c];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        zoh_sdm_chan #(.IN_W(IN_W), .ACC_W(ACC_W), .ORDER(4)) u_ch (
            .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .mute_i(mute_i),
            .x_i(feed[c]), .bit_o(bits_o[c])
        );
    end

    assign bits_vld_o = st_q.vld;
    assign act_w      = st_q.act;

endmodule

// File: rtl/zoh_sdm_chk.sv
module zoh_sdm_chk #(
    parameter int unsigned NCH  = 2,
    parameter int unsigned IN_W = 16,
    parameter int unsigned DIV  = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mute,
    input logic                tick,
    input logic                load,
    input logic [NCH*IN_W-1:0] act,
    input logic [NCH-1:0]      bits,
    input logic                bits_vld
);
    logic [7:0]     gap_q;
    logic           seen_q, m1_q, m0_q;
    logic [NCH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0; seen_q <= 1'b0; m1_q <= 1'b0; m0_q <= 1'b0; last_q <= '0;
        end else begin
            gap_q <= bits_vld ? 8'd0 : ((gap_q == 8'hFF) ? gap_q : gap_q + 8'd1);
            if (bits_vld) begin seen_q <= 1'b1; last_q <= bits; end
            if (tick) begin m1_q <= mute; m0_q <= m1_q; end
        end
    end

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_vld && seen_q) |-> (gap_q == 8'(DIV - 1))); // R1
    AST_VLD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> bits_vld); // R1
    AST_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(bits)); // R1
    AST_HOLD_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act)); // R3
    AST_MUTE_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_vld && m1_q && !m0_q) |-> (bits == {NCH{1'b1}})); // R8
    AST_MUTE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_vld && m1_q && m0_q) |-> (bits == ~last_q)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (bits == '0 && !bits_vld)); // R2

endmodule

bind zoh_sdm zoh_sdm_chk #(.NCH(NCH), .IN_W(IN_W), .DIV(zoh_sdm_pkg::MCLK_PER_TICK)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .mute(mute_i), .tick(tick_w), .load(load_w),
    .act(act_w), .bits(bits_o), .bits_vld(bits_vld_o)
);

// File: tb/zoh_sdm_tb.sv
module zoh_sdm_tb;
    localparam int NCH = 2;
    localparam int IN_W = 16;

    logic clk = 1'b0, rst_n = 1'b0, dbl = 1'b0, mute = 1'b0, svld = 1'b0;
    logic [NCH*IN_W-1:0] smp = '0;
    logic [NCH-1:0] bits;
    logic bvld;

    int n_chk = 0, n_err = 0;
    string cur_tag = "R6";

    // bench model state
    int m_div = 0, m_ph = 0;
    logic [IN_W-1:0] m_pend [NCH], m_act [NCH];
    int m_ig [NCH][4];
    bit m_bit [NCH], m_mph [NCH];
    bit m_vld = 0;

    always #10 clk = ~clk;

    zoh_sdm u_dut (
        .clk_i(clk), .rst_ni(rst_n), .dbl_i(dbl), .mute_i(mute),
        .smp_vld_i(svld), .smp_i(smp), .bits_o(bits), .bits_vld_o(bvld)
    );

    function automatic int sat24(int v);
        if (v > 8388607)  return 8388607;
        if (v < -8388607) return -8388607;
        return v;
    endfunction

    task automatic chk(string tag, int act_v, int exp_v, string what);
        n_chk++;
        if (act_v != exp_v) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
        end
    endtask

    function automatic void model_reset();
        m_div = 0; m_ph = 0; m_vld = 0;
        for (int c = 0; c < NCH; c++) begin
            m_pend[c] = '0; m_act[c] = '0; m_bit[c] = 0; m_mph[c] = 0;
            for (int k = 0; k < 4; k++) m_ig[c][k] = 0;
        end
    endfunction

    // loop update from R6/R7/R8
    function automatic void loop_step(int c, logic [IN_W-1:0] x16);
        int xs, f, n0, n1, n2, n3, v;
        if (mute) begin
            for (int k = 0; k < 4; k++) m_ig[c][k] = 0;
            m_bit[c] = !m_mph[c];
            m_mph[c] = !m_mph[c];
            return;
        end
        m_mph[c] = 0;
        xs = int'($signed(x16)) * 64;
        f  = m_bit[c] ? 2097152 : -2097152;
        n0 = sat24(m_ig[c][0] + (xs - f));
        n1 = sat24(m_ig[c][1] + (m_ig[c][0] >>> 1));
        n2 = sat24(m_ig[c][2] + (m_ig[c][1] >>> 2));
        n3 = sat24(m_ig[c][3] + (m_ig[c][2] >>> 3));
        v  = n0 + (n1 >>> 1) + (n2 >>> 2) + (n3 >>> 3);
        m_ig[c][0] = n0; m_ig[c][1] = n1; m_ig[c][2] = n2; m_ig[c][3] = n3;
        m_bit[c] = (v >= 0);
    endfunction

    // one rising edge with the inputs as currently driven (R1, R3, R4, R5)
    function automatic void model_edge();
        bit tick, ld;
        int last;
        logic [IN_W-1:0] nv;
        tick = (m_div == 5);
        ld   = tick && (m_ph == 0);
        last = dbl ? 7 : 15;
        for (int c = 0; c < NCH; c++) begin
            nv = svld ? smp[c*IN_W +: IN_W] : m_pend[c];
            if (tick) loop_step(c, ld ? nv : m_act[c]);
            if (ld)   m_act[c]  = nv;
            if (svld) m_pend[c] = smp[c*IN_W +: IN_W];
        end
        m_div = tick ? 0 : m_div + 1;
        if (tick) m_ph = (m_ph >= last) ? 0 : m_ph + 1;
        m_vld = tick;
    endfunction

    task automatic cyc();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk("R1", int'(bvld), int'(m_vld), "bits_vld_o");
        if (m_vld) begin
            for (int c = 0; c < NCH; c++)
                chk(cur_tag, int'(bits[c]), int'(m_bit[c]), $sformatf("bits_o[%0d]", c));
        end
    endtask

    function automatic logic [IN_W-1:0] rnd_smp(int span);
        int v;
        v = int'($urandom % (2 * span + 1)) - span;
        return IN_W'(v);
    endfunction

    task automatic run_random(int ncyc, int span, int strobe_pct);
        for (int i = 0; i < ncyc; i++) begin
            svld = (($urandom % 100) < strobe_pct);
            smp  = {rnd_smp(span), rnd_smp(span)};
            cyc();
        end
        svld = 1'b0;
    endtask

    task automatic wait_until(int div_v, int ph_v);
        for (int i = 0; i < 400; i++) begin
            if (m_div == div_v && m_ph == ph_v) break;
            cyc();
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20241));
        model_reset();
        // R2: quiet while reset is held
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2", int'(bits), 0, "bits_o in reset");
            chk("R2", int'(bvld), 0, "bits_vld_o in reset");
        end
        rst_n = 1'b1;

        // R1 + R6: first ticks with silence, then a normal-mode random stream
        cur_tag = "R6";
        run_random(600, 16000, 3);

        // R3: strobes placed mid-period; the last one must win at the boundary
        cur_tag = "R3";
        for (int r = 0; r < 4; r++) begin
            wait_until(2, 5);
            svld = 1'b1; smp = {16'h1234, 16'hEDCC}; cyc();
            svld = 1'b1; smp = {rnd_smp(20000), rnd_smp(20000)}; cyc();
            svld = 1'b0;
            run_random(120, 0, 0);
        end

        // R5: strobe in the very clock of a hold-boundary tick
        cur_tag = "R5";
        for (int r = 0; r < 6; r++) begin
            wait_until(5, 0);
            svld = 1'b1; smp = {rnd_smp(30000), rnd_smp(30000)};
            cyc();
            svld = 1'b0;
            run_random(60, 0, 0);
        end

        // R4: double mode, including a switch in mid-period
        cur_tag = "R4";
        wait_until(3, 12);
        dbl = 1'b1;
        run_random(1500, 16000, 6);

        // R7: full-scale inputs drive the integrators into saturation
        cur_tag = "R7";
        svld = 1'b1; smp = {16'h7FFF, 16'h7FFF}; cyc(); svld = 1'b0;
        run_random(800, 0, 0);
        svld = 1'b1; smp = {16'h8000, 16'h8000}; cyc(); svld = 1'b0;
        run_random(800, 0, 0);

        // R10: opposite extremes on the two channels
        cur_tag = "R10";
        dbl = 1'b0;
        svld = 1'b1; smp = {16'h8000, 16'h7FFF}; cyc(); svld = 1'b0;
        run_random(700, 0, 0);

        // R8: mute while samples keep arriving
        cur_tag = "R8";
        mute = 1'b1;
        run_random(240, 20000, 5);

        // R9: loop restarts from zero after mute
        cur_tag = "R9";
        mute = 1'b0;
        run_random(600, 12000, 4);
        cur_tag = "R8";
        mute = 1'b1;
        run_random(60, 12000, 4);
        cur_tag = "R9";
        mute = 1'b0;
        run_random(300, 12000, 4);

        // R2: reset in mid-stream returns everything to zero
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R2", int'(bits), 0, "bits_o after reset");
        chk("R2", int'(bvld), 0, "bits_vld_o after reset");
        rst_n = 1'b1;
        cur_tag = "R6";
        run_random(300, 16000, 4);

        finish_run();
    end

endmodule